// File: doc/BRIEF.md
# Packet Buffer Byte Window with Self-Advancing Pointer

This block gives a host byte-wide access into a small packet buffer RAM made of several 2048-byte pages. A 16-bit pointer register, loaded one byte at a time, controls every access. Its low eleven bits hold a byte offset inside a page. Bit 15 picks which page is used: the page at the head of the receive queue, or the page named by the packet number input. Bit 14 turns on auto-advance. The host reaches the RAM through four data byte lanes.

With auto-advance on, every data access uses the current offset and then increments it by one. The increment wraps inside the eleven offset bits and leaves the upper five pointer bits unchanged. With auto-advance off, the lane index (0 to 3) is added to the offset to form the address, and the pointer stays as it is. This lets a host fetch a 32-bit word as four lane accesses. Reads are registered and return data one cycle after the strobe. A read strobe and a write strobe in the same cycle are not legal. If they occur together, only the write is carried out.

The local address `addr` is decoded as follows. Value 0 is the pointer low byte and value 1 is the pointer high byte. Values 2 and 3 are unused. Values 4 to 7 are data lanes 0 to 3, and the lane index is `addr[1:0]`.

Top module: `buf_ptr_port`

## Requirements
- R1: After reset the pointer is 0, so reads of address 0 and address 1 both return 0x00.
- R2: A write to address 0 loads pointer bits [7:0], and a write to address 1 loads bits [15:8]. Reading address 0 returns bits [7:0]. Reading address 1 returns bits [15:8] ANDed with 0xF7, so bit 11 always reads as 0.
- R3: A data access with pointer bit 15 set uses page `rxHead`. With bit 15 clear it uses page `pktNum`.
- R4: With pointer bit 14 set, a data access (addresses 4 to 7) uses offset bits [10:0] for any lane. After the access, bits [10:0] become (offset+1) mod 2048, and bits [15:11] do not change.
- R5: With pointer bit 14 clear, a data access on lane L uses offset (bits[10:0]+L) mod 2048, and the pointer does not change.
- R6: `rdData` takes the value read one clock after a read strobe and holds it until the next accepted read.
- R7: When `wrEn` and `rdEn` are both high, only the write is done. `rdData` keeps its previous value, and the pointer advances at most once.
- R8: Writes to addresses 2 and 3 have no effect, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Local address: pointer bytes, unused slots, data lanes |
| wrData | input | 8 | Write data byte |
| pktNum | input | PG_W (2) | Page used when pointer bit 15 is clear |
| rxHead | input | PG_W (2) | Page at the receive queue head, used when pointer bit 15 is set |
| rdData | output | 8 | Registered read data |

## Verification
The assertions assume that `pktNum` and `rxHead` always name an existing page. They also assume that `wrEn` and `rdEn` are high together only in the single deliberate collision case. Apart from that case, the stimulus drives one strobe per cycle, changing it on the falling edge. Every page value the bench applies is within 0 to 3. The sweep fills all four pages through the auto-advancing pointer, reads them back through both page-select paths, and covers offset wrap in both pointer modes.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;
  localparam int PTR_W     = 16;
  localparam int OFS_W     = 11;
  localparam int AUTO_BIT  = 14;
  localparam int RXSEL_BIT = 15;
  localparam logic [7:0] HI_READ_MASK = 8'hF7;

  typedef struct packed {
    logic ptrLoWr;
    logic ptrHiWr;
    logic memWr;
    logic memRd;
    logic ptrLoRd;
    logic ptrHiRd;
    logic zeroRd;
  } ptrStrobes_t;
endpackage

// File: rtl/bufptr_ctrl.sv
module bufptr_ctrl
  import bufptr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  output ptrStrobes_t stb,
  output logic [1:0]  lane
);
  logic isData, isPtr, doRd;

  always_comb begin
    isData = addr[2];
    isPtr  = !addr[2] && !addr[1];
    doRd   = rdEn && !wrEn;
    lane   = addr[1:0];
    stb.ptrLoWr = wrEn && isPtr && !addr[0];
    stb.ptrHiWr = wrEn && isPtr && addr[0];
    stb.memWr   = wrEn && isData;
    stb.memRd   = doRd && isData;
    stb.ptrLoRd = doRd && isPtr && !addr[0];
    stb.ptrHiRd = doRd && isPtr && addr[0];
    stb.zeroRd  = doRd && !isData && addr[1];
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |-> !(stb.memRd || stb.ptrLoRd || stb.ptrHiRd || stb.zeroRd));
endmodule

// File: rtl/bufptr_dp.sv
module bufptr_dp
  import bufptr_pkg::*;
#(
  parameter int PAGE_COUNT = 4,
  localparam int PG_W  = $clog2(PAGE_COUNT),
  localparam int DEPTH = PAGE_COUNT * (1 << OFS_W)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ptrStrobes_t     stb,
  input  logic [1:0]      lane,
  input  logic [7:0]      wrData,
  input  logic [PG_W-1:0] pktNum,
  input  logic [PG_W-1:0] rxHead,
  output logic [7:0]      rdData
);
  logic [PTR_W-1:0]      ptr;
  logic [OFS_W-1:0]      ofs, accOfs;
  logic [PG_W-1:0]       page;
  logic [PG_W+OFS_W-1:0] memIdx;
  logic                  autoInc, access;
  logic [7:0]            mem [DEPTH];

  always_comb begin
    ofs     = ptr[OFS_W-1:0];
    autoInc = ptr[AUTO_BIT];
    page    = ptr[RXSEL_BIT] ? rxHead : pktNum;
    accOfs  = autoInc ? ofs : ofs + OFS_W'(lane);
    memIdx  = {page, accOfs};
    access  = stb.memWr || stb.memRd;
  end

  always_ff @(posedge clk) begin
    if (stb.memWr) mem[memIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.ptrLoWr) begin
      ptr[7:0] <= wrData;
    end else if (stb.ptrHiWr) begin
      ptr[15:8] <= wrData;
    end else if (access && autoInc) begin
      ptr[OFS_W-1:0] <= ofs + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.memRd) begin
      rdData <= mem[memIdx];
    end else if (stb.ptrLoRd) begin
      rdData <= ptr[7:0];
    end else if (stb.ptrHiRd) begin
      rdData <= ptr[15:8] & HI_READ_MASK;
    end else if (stb.zeroRd) begin
      rdData <= '0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (ptr == '0 && rdData == '0));
  assert_hi_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrHiRd |=> (rdData[3] == 1'b0));
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (access && autoInc) |=> (ptr[OFS_W-1:0] == $past(ptr[OFS_W-1:0]) + 1'b1
                             && ptr[15:OFS_W] == $past(ptr[15:OFS_W])));
  assert_fixed_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (access && !autoInc) |=> $stable(ptr));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.memRd || stb.ptrLoRd || stb.ptrHiRd || stb.zeroRd) |=> $stable(rdData));
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroRd |=> (rdData == 8'h00));
endmodule

// File: rtl/buf_ptr_port.sv
module buf_ptr_port
  import bufptr_pkg::*;
#(
  parameter int PAGE_COUNT = 4,
  localparam int PG_W = $clog2(PAGE_COUNT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [2:0]      addr,
  input  logic [7:0]      wrData,
  input  logic [PG_W-1:0] pktNum,
  input  logic [PG_W-1:0] rxHead,
  output logic [7:0]      rdData
);
  ptrStrobes_t stb;
  logic [1:0]  lane;

  bufptr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .stb(stb), .lane(lane)
  );

  bufptr_dp #(.PAGE_COUNT(PAGE_COUNT)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lane(lane), .wrData(wrData),
    .pktNum(pktNum), .rxHead(rxHead), .rdData(rdData)
  );
endmodule

// File: tb/test_buf_ptr_port.sv
module test_buf_ptr_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] pktNum = '0, rxHead = '0;
  logic [7:0] rdData;
  int total = 0, bad = 0;
  logic [7:0] got, held;

  always #5 clk = ~clk;

  buf_ptr_port i_buf_ptr_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .pktNum(pktNum), .rxHead(rxHead), .rdData(rdData)
  );

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doRd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic setPtr(input logic [15:0] v);
    doWr(3'd0, v[7:0]);
    doWr(3'd1, v[15:8]);
  endtask

  task automatic checkPtr(input string req, input logic [15:0] v);
    logic [7:0] d;
    doRd(3'd0, d); check(req, d, v[7:0]);
    doRd(3'd1, d); check(req, d, v[15:8] & 8'hF7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkPtr("R1 reset pointer", 16'h0000);

    // R2: byte loads and masked high readback
    setPtr(16'hFF5A);
    checkPtr("R2 pointer readback", 16'hFF5A);

    // R4/R3: fill every page through the advancing pointer
    for (int p = 0; p < 4; p++) begin
      pktNum = 2'(p);
      setPtr(16'h4000);
      for (int i = 0; i < 16; i++) doWr(3'(4 + (i % 4)), pat(p, i));
      checkPtr("R4 advance count", 16'h4010);
    end
    for (int p = 0; p < 4; p++) begin
      pktNum = 2'(p); rxHead = 2'(3 - p);
      setPtr(16'h4000);
      for (int i = 0; i < 16; i++) begin
        doRd(3'(4 + ((i + 1) % 4)), got);
        check("R3 R4 tx page readback", got, pat(p, i));
      end
      setPtr(16'hC000);
      for (int i = 0; i < 16; i++) begin
        doRd(3'd4, got);
        check("R3 rx page readback", got, pat(3 - p, i));
      end
    end

    // R4: wrap inside eleven bits, upper bits kept
    pktNum = 2'd1;
    setPtr(16'h7FFE);
    doWr(3'd4, 8'hA1);
    doWr(3'd5, 8'hA2);
    checkPtr("R4 wrap", 16'h7800);
    doWr(3'd6, 8'hA3);
    checkPtr("R4 after wrap", 16'h7801);

    // R5: lane offsets with wrap, pointer unchanged
    setPtr(16'h07FE);
    doRd(3'd4, got); check("R5 lane0", got, 8'hA1);
    doRd(3'd5, got); check("R5 lane1", got, 8'hA2);
    doRd(3'd6, got); check("R5 lane2 wrap", got, 8'hA3);
    doRd(3'd7, got); check("R5 lane3 wrap", got, pat(1, 1));
    checkPtr("R5 pointer fixed", 16'h07FE);

    pktNum = 2'd2;
    setPtr(16'h0100);
    for (int l = 0; l < 4; l++) doWr(3'(4 + l), 8'(8'h50 + l));
    checkPtr("R5 pointer fixed after writes", 16'h0100);
    for (int l = 0; l < 4; l++) begin
      doRd(3'(4 + l), got); check("R5 lane readback", got, 8'(8'h50 + l));
    end
    rxHead = 2'd2; pktNum = 2'd0;
    setPtr(16'h8100);
    doRd(3'd5, got); check("R3 rx select fixed mode", got, 8'h51);

    // R6: data holds while idle
    held = got;
    repeat (4) @(negedge clk);
    check("R6 hold idle", rdData, held);
    doWr(3'd4, 8'hEE);
    check("R6 hold across write", rdData, held);

    // R8: unused slots
    setPtr(16'h0123);
    doWr(3'd2, 8'h99);
    doWr(3'd3, 8'h77);
    checkPtr("R8 writes ignored", 16'h0123);
    doRd(3'd2, got); check("R8 read slot 2", got, 8'h00);
    doRd(3'd3, got); check("R8 read slot 3", got, 8'h00);

    // R7: simultaneous strobes
    pktNum = 2'd0;
    setPtr(16'h4200);
    doRd(3'd1, held); check("R2 high read", held, 8'h42);
    @(negedge clk); wrEn = 1'b1; rdEn = 1'b1; addr = 3'd4; wrData = 8'hC3;
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    check("R7 read suppressed", rdData, 8'h42);
    checkPtr("R7 single advance", 16'h4201);
    setPtr(16'h0200);
    doRd(3'd4, got); check("R7 write done", got, 8'hC3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule